// File: doc/BRIEF.md
# GPIO Interrupt Cause Collector

This block turns a 32-bit vector of input pin levels into a small set of interrupt requests for an upstream interrupt controller. The input vector is already polarity-corrected, so a logic 1 always means "active". Two kinds of source exist for every pin. The first is a sticky edge record, set when the pin goes from 0 to 1. The second is a live level, taken straight from the pin with no storage. Each kind has its own enable mask.

Software reaches three registers over a simple write/read port: the edge record, the edge enable mask and the level enable mask. An edge record bit is acknowledged by writing a word that is all ones except for a 0 in that bit. A new edge that coincides with the acknowledge wins, so no event is lost. The enabled edge and level sources are merged per pin. Each run of eight consecutive pins is then ORed onto one output line, so the controller sees one request per group of eight.

Falling-edge sensing is obtained upstream by inverting the pin's polarity before it reaches this block. The block itself only records 0-to-1 transitions.

Top module: `gpio_irq_summary`

## Requirements
- R1: During and after reset the edge record, edge enable mask and level enable mask all read 0, and every `irq_group` line is 0.
- R2: A write at address 0x18 loads the edge enable mask with `reg_wdata` on that clock edge. A read at 0x18 returns the mask in the same cycle the address is presented.
- R3: A write at address 0x1C loads the level enable mask. A read at 0x1C returns it.
- R4: A pin that was 0 at one clock edge and is 1 at the next sets its edge record bit on that second edge. Falling transitions and steady levels set nothing. Address 0x14 reads the record.
- R5: A write at 0x14 clears every record bit written as 0 and leaves every bit written as 1 unchanged. A bit that is never acknowledged stays set.
- R6: A rising transition captured on the same edge as a clearing write to that bit leaves the bit set.
- R7: A pin whose level enable bit is 1 drives its group line high in the same cycle the pin is 1, and releases it as soon as the pin returns to 0.
- R8: An edge record bit is recorded even while its edge enable bit is 0. It reaches the group line only while that enable bit is 1.
- R9: `irq_group[g]` is 1 exactly when some pin in 8g..8g+7 has its level source or its edge source active and enabled.
- R10: Writes to any address other than 0x14, 0x18 and 0x1C change no register. Reads from such addresses return 0.
- R11: A pin that is already 1 when reset is released does not create an edge record on the first clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_level | input | 32 | Polarity-corrected pin levels, synchronous to clk |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_group | output | 4 | One request per group of eight pins |

## Verification
A stuck or spuriously set edge record bit shows up two ways. It appears on the 0x14 readback in the cycle after the offending clock edge. Once its enable is set, it also appears on the owning group line. A wrong acknowledge or priority rule therefore shows within one cycle of the write. A level-path fault that latches or delays the pin appears in the same cycle as the pin change, because that path has no register. The reference model compares the group lines and the readback on every cycle, so a divergence is reported on the first cycle it reaches a port.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned GIRQ_ADDR_W = 8;

  // Register byte addresses; software depends on these values
  localparam logic [GIRQ_ADDR_W-1:0] OFS_EDGE_REC  = 8'h14;
  localparam logic [GIRQ_ADDR_W-1:0] OFS_EDGE_EN   = 8'h18;
  localparam logic [GIRQ_ADDR_W-1:0] OFS_LEVEL_EN  = 8'h1C;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_REC   = 2'd1,
    SEL_EDGE  = 2'd2,
    SEL_LEVEL = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [GIRQ_ADDR_W-1:0] addr);
    reg_sel_e sel;
    case (addr)
      OFS_EDGE_REC: sel = SEL_REC;
      OFS_EDGE_EN:  sel = SEL_EDGE;
      OFS_LEVEL_EN: sel = SEL_LEVEL;
      default:      sel = SEL_NONE;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/gpio_irq_regfile.sv
module gpio_irq_regfile
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [GIRQ_ADDR_W-1:0] addr,
  input  logic [PINS-1:0]        wdata,
  input  logic [PINS-1:0]        edge_rec,
  output logic [PINS-1:0]        edge_en,
  output logic [PINS-1:0]        level_en,
  output logic                   rec_ack_en,
  output logic [PINS-1:0]        rdata
);

  reg_sel_e        sel;
  logic            edge_wr;
  logic            level_wr;
  logic [PINS-1:0] edge_en_q;
  logic [PINS-1:0] level_en_q;

  assign sel        = decode_addr(addr);
  assign edge_wr    = wr_en && (sel == SEL_EDGE);
  assign level_wr   = wr_en && (sel == SEL_LEVEL);
  assign rec_ack_en = wr_en && (sel == SEL_REC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_en_q  <= '0;
      level_en_q <= '0;
    end else begin
      if (edge_wr)  edge_en_q  <= wdata;
      if (level_wr) level_en_q <= wdata;
    end
  end

  assign edge_en  = edge_en_q;
  assign level_en = level_en_q;

  always_comb begin
    unique case (sel)
      SEL_REC:   rdata = edge_rec;
      SEL_EDGE:  rdata = edge_en_q;
      SEL_LEVEL: rdata = level_en_q;
      default:   rdata = '0;
    endcase
  end

  // R2
  edge_en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_wr |=> (edge_en == $past(wdata)))
    else $error("edge enable did not load written word");

  // R3
  level_en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_wr |=> (level_en == $past(wdata)))
    else $error("level enable did not load written word");

  // R10
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel == SEL_NONE)) |=> ($stable(edge_en) && $stable(level_en)))
    else $error("write to unmapped address changed an enable mask");

endmodule

// File: rtl/gpio_edge_record.sv
module gpio_edge_record #(
  parameter int unsigned PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_level,
  input  logic            ack_en,
  input  logic [PINS-1:0] ack_keep,
  output logic [PINS-1:0] edge_rec,
  output logic [PINS-1:0] rise_evt
);

  logic [PINS-1:0] prev_q;
  logic [PINS-1:0] rec_q;
  logic            armed_q;

  // A 0-to-1 step between two sampled values, suppressed until one sample exists
  function automatic logic [PINS-1:0] find_rises(
    input logic [PINS-1:0] now_v,
    input logic [PINS-1:0] was_v,
    input logic            armed
  );
    return armed ? (now_v & ~was_v) : '0;
  endfunction

  // Acknowledge keeps bits written as 1; fresh rises are ORed in afterwards
  function automatic logic [PINS-1:0] update_record(
    input logic [PINS-1:0] cur,
    input logic [PINS-1:0] rises,
    input logic            ack,
    input logic [PINS-1:0] keep
  );
    logic [PINS-1:0] kept;
    kept = ack ? (cur & keep) : cur;
    return kept | rises;
  endfunction

  assign rise_evt = find_rises(pin_level, prev_q, armed_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      rec_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= pin_level;
      armed_q <= 1'b1;
      rec_q   <= update_record(rec_q, rise_evt, ack_en, ack_keep);
    end
  end

  assign edge_rec = rec_q;

  // R6
  rise_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt != '0) |=> ((edge_rec & $past(rise_evt)) == $past(rise_evt)))
    else $error("captured rise missing from edge record");

  // R5
  record_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_en |=> ((edge_rec & $past(edge_rec)) == $past(edge_rec)))
    else $error("edge record bit dropped without acknowledge");

  // R4
  no_spurious_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_en && rise_evt == '0) |=> $stable(edge_rec))
    else $error("edge record changed with no rise and no acknowledge");

endmodule

// File: rtl/gpio_group_or.sv
module gpio_group_or #(
  parameter int unsigned PINS  = 32,
  parameter int unsigned GROUP = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PINS-1:0]         pending,
  output logic [PINS/GROUP-1:0]   irq
);

  localparam int unsigned GROUPS = PINS / GROUP;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign irq[g] = |pending[g*GROUP +: GROUP];
  end

  // R9
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |-> (irq == '0))
    else $error("group line active with nothing pending");

  // R9
  some_line_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending != '0) |-> (irq != '0))
    else $error("pending pin reached no group line");

endmodule

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS   = 32,
  parameter int unsigned GROUP  = 8,
  localparam int unsigned GROUPS = PINS / GROUP
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PINS-1:0]        pin_level,
  input  logic                   reg_wr_en,
  input  logic [GIRQ_ADDR_W-1:0] reg_addr,
  input  logic [PINS-1:0]        reg_wdata,
  output logic [PINS-1:0]        reg_rdata,
  output logic [GROUPS-1:0]      irq_group
);

  logic [PINS-1:0] edge_rec;
  logic [PINS-1:0] rise_evt;
  logic [PINS-1:0] edge_en;
  logic [PINS-1:0] level_en;
  logic            rec_ack_en;
  logic [PINS-1:0] pending;

  // Per-pin merge of the live level source and the sticky edge source
  function automatic logic [PINS-1:0] merge_sources(
    input logic [PINS-1:0] lvl,
    input logic [PINS-1:0] lvl_en,
    input logic [PINS-1:0] rec,
    input logic [PINS-1:0] rec_en
  );
    return (lvl & lvl_en) | (rec & rec_en);
  endfunction

  gpio_irq_regfile #(.PINS(PINS)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr_en),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .edge_rec   (edge_rec),
    .edge_en    (edge_en),
    .level_en   (level_en),
    .rec_ack_en (rec_ack_en),
    .rdata      (reg_rdata)
  );

  gpio_edge_record #(.PINS(PINS)) rec_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_level (pin_level),
    .ack_en    (rec_ack_en),
    .ack_keep  (reg_wdata),
    .edge_rec  (edge_rec),
    .rise_evt  (rise_evt)
  );

  assign pending = merge_sources(pin_level, level_en, edge_rec, edge_en);

  gpio_group_or #(.PINS(PINS), .GROUP(GROUP)) grp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .pending (pending),
    .irq     (irq_group)
  );

  // R1
  masked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_en == '0 && level_en == '0) |-> (irq_group == '0))
    else $error("group line active with both masks clear");

  // R7
  level_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_level & level_en) != '0) |-> (irq_group != '0))
    else $error("enabled active level did not reach a group line");

  // R8
  enabled_rec_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_rec & edge_en) != '0) |-> (irq_group != '0))
    else $error("enabled edge record did not reach a group line");

  // R11
  first_edge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rise_evt == '0))
    else $error("rise reported before any sample was taken");

endmodule

// File: tb/gpio_irq_summary_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_summary_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_level = '0;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  irq_group;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";

  // Reference state
  bit [31:0] m_rec = 0, m_een = 0, m_len = 0, m_prev = 0;
  bit        m_armed = 0;

  always #2 clk = ~clk;

  gpio_irq_summary dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_level (pin_level),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_group (irq_group)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_now();
    bit [3:0]  exp_irq;
    bit [31:0] exp_rd;
    exp_irq = 0;
    for (int p = 0; p < 32; p++) begin
      bool_blk: begin
        bit act;
        act = (pin_level[p] && m_len[p]) || (m_rec[p] && m_een[p]);
        if (act) exp_irq[p / 8] = 1'b1;
      end
    end
    if (reg_addr == 8'h14) exp_rd = m_rec;
    else if (reg_addr == 8'h18) exp_rd = m_een;
    else if (reg_addr == 8'h1C) exp_rd = m_len;
    else exp_rd = 0;
    check(cur_req, "irq_group", {28'd0, irq_group}, {28'd0, exp_irq});
    check(cur_req, "reg_rdata", reg_rdata, exp_rd);
  endtask

  task automatic model_clock();
    bit [31:0] rises;
    rises = 0;
    if (m_armed)
      for (int p = 0; p < 32; p++)
        if (pin_level[p] && !m_prev[p]) rises[p] = 1'b1;
    if (reg_wr_en && reg_addr == 8'h14) begin
      for (int p = 0; p < 32; p++)
        if (!reg_wdata[p]) m_rec[p] = 1'b0;
    end
    m_rec = m_rec | rises;
    if (reg_wr_en && reg_addr == 8'h18) m_een = reg_wdata;
    if (reg_wr_en && reg_addr == 8'h1C) m_len = reg_wdata;
    m_prev  = pin_level;
    m_armed = 1'b1;
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic step(input logic [31:0] pins, input logic wr, input logic [7:0] addr, input logic [31:0] wd);
    pin_level = pins;
    reg_wr_en = wr;
    reg_addr  = addr;
    reg_wdata = wd;
    #1;
    compare_now();
    @(posedge clk);
    model_clock();
    @(negedge clk);
  endtask

  task automatic rd(input logic [31:0] pins, input logic [7:0] addr);
    step(pins, 1'b0, addr, 32'h0);
  endtask

  initial begin
    #(4 * 150000);
    miscompares++;
    $display("FAIL watchdog expired, actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] pins;
    // R1 and R11: pins high throughout reset
    pin_level = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cur_req = "R1";
    reg_addr = 8'h14; #1; compare_now();
    reg_addr = 8'h18; #1; compare_now();
    reg_addr = 8'h1C; #1; compare_now();
    rst_n = 1'b1;

    cur_req = "R11";
    rd(32'hFFFF_FFFF, 8'h14);
    rd(32'hFFFF_FFFF, 8'h14);
    rd(32'h0, 8'h14);
    check("R11", "edge record after arming", reg_rdata, 32'h0);

    cur_req = "R2";
    step(32'h0, 1'b1, 8'h18, 32'hA5A5_0F0F);
    rd(32'h0, 8'h18);
    step(32'h0, 1'b1, 8'h18, 32'h0);

    cur_req = "R3";
    step(32'h0, 1'b1, 8'h1C, 32'h3C3C_F00F);
    rd(32'h0, 8'h1C);
    step(32'h0, 1'b1, 8'h1C, 32'h0);

    cur_req = "R4";
    rd(32'h0000_0101, 8'h14);
    rd(32'h0000_0101, 8'h14);
    rd(32'h0000_0001, 8'h14);
    rd(32'h8000_0000, 8'h14);
    rd(32'h0, 8'h14);
    rd(32'h0, 8'h14);

    cur_req = "R5";
    step(32'h0, 1'b1, 8'h14, 32'hFFFF_FEFF);
    rd(32'h0, 8'h14);
    step(32'h0, 1'b1, 8'h14, 32'hFFFF_FFFF);
    rd(32'h0, 8'h14);
    step(32'h0, 1'b1, 8'h14, 32'h0);
    rd(32'h0, 8'h14);

    cur_req = "R6";
    rd(32'h0, 8'h14);
    step(32'h0000_0010, 1'b1, 8'h14, 32'h0);
    rd(32'h0000_0010, 8'h14);
    step(32'h0, 1'b1, 8'h14, 32'h0);

    cur_req = "R7";
    step(32'h0, 1'b1, 8'h1C, 32'h0100_0000);
    rd(32'h0100_0000, 8'h00);
    rd(32'h0, 8'h00);
    rd(32'h0100_0000, 8'h00);
    step(32'h0, 1'b1, 8'h1C, 32'h0);

    cur_req = "R8";
    step(32'h0, 1'b1, 8'h14, 32'h0);
    rd(32'h0002_0000, 8'h14);
    rd(32'h0, 8'h14);
    step(32'h0, 1'b1, 8'h18, 32'h0002_0000);
    rd(32'h0, 8'h18);
    step(32'h0, 1'b1, 8'h18, 32'h0);
    rd(32'h0, 8'h14);

    cur_req = "R9";
    step(32'h0, 1'b1, 8'h1C, 32'hFFFF_FFFF);
    for (int p = 0; p < 32; p += 5) rd(32'h1 << p, 8'h1C);
    rd(32'h8000_8000, 8'h1C);
    step(32'h0, 1'b1, 8'h1C, 32'h0);

    cur_req = "R10";
    step(32'h0, 1'b1, 8'h10, 32'hFFFF_FFFF);
    step(32'h0, 1'b1, 8'h00, 32'hFFFF_FFFF);
    step(32'h0, 1'b1, 8'h1B, 32'hFFFF_FFFF);
    rd(32'h0, 8'h18);
    rd(32'h0, 8'h1C);
    rd(32'h0, 8'h20);

    // Mixed traffic, every cycle compared
    cur_req = "R9";
    pins = 32'h0;
    for (int n = 0; n < 2000; n++) begin
      logic [7:0] a;
      logic       w;
      int         k;
      k = int'($urandom_range(0, 4));
      a = (k == 0) ? 8'h14 : (k == 1) ? 8'h18 : (k == 2) ? 8'h1C : (k == 3) ? 8'h10 : 8'h04;
      w = ($urandom_range(0, 3) == 0);
      pins = pins ^ ($urandom & $urandom & $urandom);
      step(pins, w, a, (k == 0) ? ~($urandom & $urandom) : $urandom);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule